// File: doc/BRIEF.md
# Inhibit-Sequenced Five-Port Talker

The block sends a snapshot of five byte-wide input ports as one binary group on a byte stream. When the talk select input goes high, it raises an inhibit output for a set number of clocks so that the external logic can settle. It latches all five ports in the last inhibit cycle and then drops inhibit. The five bytes go out over a valid/ready interface, highest-numbered port first. The end-of-message flag is set on the fifth byte only.

When the final byte of a group is accepted, the block runs the inhibit-and-latch sequence again at once, so the next group is ready. While talk stays selected, groups keep flowing without any reselection. A session of N complete groups therefore yields N+1 inhibit pulses. If talk is dropped after that early sample, the sample is kept and is sent on the next selection. If talk is dropped part-way through a group, the rest of the group is discarded and the next selection takes a new sample. A separate trigger input stretches a single-cycle request into an output pulse of fixed length. This stretcher is independent of the talker.

Top module: `port_talker`

## Requirements
- R1: During and immediately after reset, `inhibit`, `tx_valid`, `tx_last` and `trig_out` are low.
- R2: When `talk_en` is sampled high with the talker idle, `inhibit` rises on the next cycle and stays high for exactly INH_CYCLES consecutive cycles.
- R3: The ports are latched in the last cycle of each inhibit window. `inhibit` and `tx_valid` are never high together.
- R4: Byte k of a group (k = 0..NPORTS-1) carries port NPORTS-k. Port p occupies `port_in[8*(p-1) +: 8]`, so the first byte is the highest port and the last byte is port 1.
- R5: `tx_last` is high only together with the fifth (final) byte of a group.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values.
- R7: Acceptance of the final byte starts a new inhibit window in the following cycle, and groups keep coming while `talk_en` stays high. N complete groups in one selection produce N+1 inhibit pulses.
- R8: `tx_valid` is low whenever `talk_en` is low. Dropping `talk_en` mid-group discards the unsent bytes, and the next selection begins with a new inhibit window and the first byte.
- R9: When `talk_en` drops after the early sample of R7, that sample is kept. On reselection it is sent starting at the first byte, with no new inhibit pulse.
- R10: A `trig_req` sampled high drives `trig_out` high from the next cycle for exactly TRIG_CYCLES cycles. A new request while it is high restarts the count.
- R11: Trigger requests have no effect on the talker's byte stream or inhibit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| talk_en | input | 1 | Talker selected |
| port_in | input | NPORTS*W | Concatenated input ports, port 1 in the low byte |
| inhibit | output | 1 | High while the external ports must stay stable |
| tx_data | output | W | Outgoing byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of the group |
| tx_ready | input | 1 | Sink accepts the byte |
| trig_req | input | 1 | Trigger request |
| trig_out | output | 1 | Stretched trigger pulse |

## Verification
The hardest states to reach from the ports are the parked state after an early sample and a deselection in the middle of a group. Both depend on exactly when `talk_en` falls relative to the last handshake. The bench drives `talk_en` from its own count of accepted bytes, which lets it stop after a whole number of groups or after two or three bytes. This is repeated across group counts and two ready patterns. It changes the port pattern at every inhibit rise, so a stale or skipped sample shows up as a wrong byte.

// File: rtl/talker_pkg.sv
package talker_pkg;

  typedef enum logic [1:0] {
    TK_IDLE = 2'd0,
    TK_INH  = 2'd1,
    TK_SEND = 2'd2,
    TK_PARK = 2'd3
  } tk_state_e;

  // 1-based port number carried by lane 'lane' of a group of 'nports'
  function automatic int unsigned port_for_lane(input int unsigned lane,
                                                input int unsigned nports);
    return nports - lane;
  endfunction

  function automatic logic lane_is_final(input int unsigned lane,
                                         input int unsigned nports);
    return lane == nports - 1;
  endfunction

endpackage

// File: rtl/inhibit_timer.sv
module inhibit_timer #(
  parameter int unsigned INH_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int unsigned CW = (INH_CYCLES < 2) ? 1 : $clog2(INH_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(INH_CYCLES - 1);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign done = active && (cnt == '0);

  a_r2_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);
  a_r2_no_restart_inside: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/sample_bank.sv
module sample_bank #(
  parameter int unsigned NPORTS = 5,
  parameter int unsigned W      = 8,
  parameter int unsigned LANE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [NPORTS*W-1:0]   port_in,
  input  logic [LANE_W-1:0]     lane,
  output logic [W-1:0]          lane_byte
);
  import talker_pkg::*;

  logic [W-1:0] held [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)       held[p] <= '0;
      else if (capture) held[p] <= port_in[p*W +: W];
    end
  end

  always_comb begin
    lane_byte = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (port_for_lane(32'(lane), NPORTS) == p + 1) lane_byte = held[p];
    end
  end

endmodule

// File: rtl/talk_fsm.sv
module talk_fsm #(
  parameter int unsigned NPORTS = 5,
  parameter int unsigned LANE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    talk_en,
  input  logic                    inh_done,
  input  logic                    xfer,
  output talker_pkg::tk_state_e   state,
  output logic [LANE_W-1:0]       lane,
  output logic                    start_inh,
  output logic                    at_final
);
  import talker_pkg::*;

  tk_state_e nxt;

  assign at_final  = lane_is_final(32'(lane), NPORTS);
  assign start_inh = ((state == TK_IDLE) && talk_en) ||
                     ((state == TK_SEND) && talk_en && xfer && at_final);

  always_comb begin
    nxt = state;
    unique case (state)
      TK_IDLE: if (talk_en) nxt = TK_INH;
      TK_INH:  if (inh_done) nxt = talk_en ? TK_SEND : TK_PARK;
      TK_SEND: begin
        if (!talk_en)                nxt = TK_IDLE;
        else if (xfer && at_final)   nxt = TK_INH;
      end
      TK_PARK: if (talk_en) nxt = TK_SEND;
      default: nxt = TK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TK_IDLE;
      lane  <= '0;
    end else begin
      state <= nxt;
      if (nxt != TK_SEND)                    lane <= '0;
      else if (state == TK_SEND && xfer)     lane <= lane + 1'b1;
    end
  end

  a_r9_park_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TK_PARK && talk_en) |=> (state == TK_SEND && lane == '0));
  a_r8_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TK_SEND && !talk_en) |=> (state == TK_IDLE));

endmodule

// File: rtl/trig_stretch.sv
module trig_stretch #(
  parameter int unsigned TRIG_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse
);
  localparam int unsigned CW = $clog2(TRIG_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (req)        cnt <= CW'(TRIG_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);

  a_r10_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(req));
  a_r10_req_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> pulse);

endmodule

// File: rtl/port_talker.sv
module port_talker #(
  parameter int unsigned NPORTS      = 5,
  parameter int unsigned W           = 8,
  parameter int unsigned INH_CYCLES  = 3,
  parameter int unsigned TRIG_CYCLES = 10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 talk_en,
  input  logic [NPORTS*W-1:0]  port_in,
  output logic                 inhibit,
  output logic [W-1:0]         tx_data,
  output logic                 tx_valid,
  output logic                 tx_last,
  input  logic                 tx_ready,
  input  logic                 trig_req,
  output logic                 trig_out
);
  import talker_pkg::*;

  localparam int unsigned LANE_W = (NPORTS < 2) ? 1 : $clog2(NPORTS);

  tk_state_e         state;
  logic [LANE_W-1:0] lane;
  logic              start_inh;
  logic              inh_done;
  logic              at_final;
  logic              xfer;
  logic              capture_evt;

  assign xfer        = tx_valid && tx_ready;
  assign capture_evt = inh_done;

  talk_fsm #(.NPORTS(NPORTS), .LANE_W(LANE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .talk_en(talk_en), .inh_done(inh_done),
    .xfer(xfer), .state(state), .lane(lane), .start_inh(start_inh),
    .at_final(at_final)
  );

  inhibit_timer #(.INH_CYCLES(INH_CYCLES)) u_inh (
    .clk(clk), .rst_n(rst_n), .start(start_inh),
    .active(inhibit), .done(inh_done)
  );

  sample_bank #(.NPORTS(NPORTS), .W(W), .LANE_W(LANE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .capture(capture_evt), .port_in(port_in),
    .lane(lane), .lane_byte(tx_data)
  );

  trig_stretch #(.TRIG_CYCLES(TRIG_CYCLES)) u_trig (
    .clk(clk), .rst_n(rst_n), .req(trig_req), .pulse(trig_out)
  );

  assign tx_valid = (state == TK_SEND) && talk_en;
  assign tx_last  = tx_valid && at_final;

  a_r3_inhibit_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(inhibit && tx_valid));
  a_r2_state_tracks_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TK_INH) == inhibit);
  a_r3_fall_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inhibit) |-> $past(capture_evt));
  a_r7_prefetch_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && tx_last) |=> inhibit);
  a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || ($stable(tx_data) && $stable(tx_last))));
  a_r8_no_valid_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !talk_en |-> !tx_valid);

endmodule

// File: tb/port_talker_bench.sv
module port_talker_bench;
  localparam int unsigned NP  = 5;
  localparam int unsigned INH = 3;
  localparam int unsigned TRG = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          talk_en;
  logic [NP*8-1:0] port_in;
  logic          inhibit;
  logic [7:0]    tx_data;
  logic          tx_valid;
  logic          tx_last;
  logic          tx_ready;
  logic          trig_req;
  logic          trig_out;

  always #2.5 clk = ~clk;

  port_talker #(.NPORTS(NP), .W(8), .INH_CYCLES(INH), .TRIG_CYCLES(TRG)) u_port_talker (
    .clk(clk), .rst_n(rst_n), .talk_en(talk_en), .port_in(port_in),
    .inhibit(inhibit), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .trig_req(trig_req),
    .trig_out(trig_out)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int id, input int port);
    return 8'((id * 53 + port * 29 + 7) & 255);
  endfunction

  // monitor state
  int  inh_cnt = 0, inh_len = 0, pending_id = 0, group_id = 0;
  int  pos = 0, grp_done = 0;
  bit  prev_inh = 0, stall = 0, rtog = 0, was_stall = 0, mon_on = 0;
  logic [7:0] held_d;
  logic       held_l;

  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (inhibit && !prev_inh) begin
        inh_cnt++;
        inh_len = 0;
        for (int p = 1; p <= NP; p++) port_in[(p-1)*8 +: 8] = pat(inh_cnt, p);
      end
      if (inhibit) inh_len++;
      if (!inhibit && prev_inh) begin
        check(inh_len == INH, "R2 inhibit length", inh_len, INH);
        pending_id = inh_cnt;
      end
      prev_inh = inhibit;
      check(!(inhibit && tx_valid), "R3 inhibit with valid", int'(tx_valid), 0);
      if (!talk_en) check(!tx_valid, "R8 valid while deselected", int'(tx_valid), 0);
      if (was_stall && tx_valid) begin
        check(tx_data == held_d, "R6 data held", tx_data, held_d);
        check(tx_last == held_l, "R6 last held", tx_last, held_l);
      end
      rtog = ~rtog;
      tx_ready = stall ? rtog : 1'b1;
      was_stall = tx_valid && !tx_ready;
      held_d = tx_data;
      held_l = tx_last;
      if (tx_valid && tx_ready) begin
        if (pos == 0) group_id = pending_id;
        check(tx_data == pat(group_id, NP - pos), "R4 byte order/value",
              tx_data, pat(group_id, NP - pos));
        check(tx_last == (pos == NP - 1), "R5 last flag", tx_last, pos == NP - 1);
        pos++;
        if (pos == NP) begin pos = 0; grp_done++; end
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_session(input int n, input bit s, input bit with_trig);
    int base, gd0, inh0;
    stall = s;
    base = inh_cnt;
    gd0 = grp_done;
    @(negedge clk);
    talk_en = 1'b1;
    if (with_trig) trig_req = 1'b1;
    @(negedge clk);
    trig_req = 1'b0;
    while (grp_done != gd0 + n) @(negedge clk);
    talk_en = 1'b0;
    wait_cycles(INH + 4);
    check(inh_cnt - base == n + 1, "R7 N+1 inhibit pulses", inh_cnt - base, n + 1);
    check(!inhibit && !tx_valid, "R9 parked quietly", int'(inhibit), 0);
    // reselect from parked sample: no new inhibit
    inh0 = inh_cnt;
    talk_en = 1'b1;
    while (pos != 1) @(negedge clk);
    check(inh_cnt == inh0, "R9 no new sample on resume", inh_cnt, inh0);
    while (pos != 3) @(negedge clk);
    talk_en = 1'b0;          // abort mid-group
    @(negedge clk);
    #2;
    check(!tx_valid, "R8 valid drops on abort", int'(tx_valid), 0);
    pos = 0;
    wait_cycles(4);
    check(!inhibit && inh_cnt == inh0, "R8 idle after abort", inh_cnt, inh0);
  endtask

  initial begin
    int hi;
    rst_n = 1'b0; talk_en = 1'b0; trig_req = 1'b0; tx_ready = 1'b1;
    port_in = '0;
    wait_cycles(4);
    #1;
    check(!inhibit, "R1 inhibit reset", int'(inhibit), 0);
    check(!tx_valid && !tx_last, "R1 valid reset", int'(tx_valid), 0);
    check(!trig_out, "R1 trigger reset", int'(trig_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    wait_cycles(2);
    check(!inhibit && !tx_valid, "R1 idle after reset", int'(inhibit), 0);

    for (int s = 0; s < 2; s++)
      for (int n = 1; n <= 3; n++)
        run_session(n, s[0], (s == 1 && n == 2));   // R11 trigger mid-session

    // R10 single request
    @(negedge clk);
    trig_req = 1'b1;
    @(negedge clk);
    trig_req = 1'b0;
    hi = 0;
    #1;
    while (trig_out) begin hi++; @(negedge clk); #1; end
    check(hi == TRG, "R10 pulse length", hi, TRG);

    // R10 retrigger after 3 cycles
    @(negedge clk);
    trig_req = 1'b1;
    @(negedge clk);
    trig_req = 1'b0;
    wait_cycles(2);
    trig_req = 1'b1;
    @(negedge clk);
    trig_req = 1'b0;
    hi = 3;
    #1;
    while (trig_out) begin hi++; @(negedge clk); #1; end
    check(hi == TRG + 3, "R10 retrigger restarts", hi, TRG + 3);
    check(!inhibit && !tx_valid, "R11 talker untouched by trigger", int'(inhibit), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule